// File: doc/BRIEF.md
# Selectable Serial Pattern Generator

The block emits one of three fixed, endlessly repeating bit strings on a single serial output: `11001`, `101011` or `1011011`. Each string has its own chain of D flip-flops. On every active clock edge the top stage takes a value from a small combinational feedback function of the chain. Every other stage copies the stage above it. The serial bit is always the top stage of the active chain, so the chain holds a window of the most recent output bits, with the newest bit at the top.

All storage updates on the falling edge of `clk`. A synchronous reset loads each chain with a seed that lies inside its own cycle, so the first bit after reset is the first bit of the chosen string. The pattern choice is held in a small mode register, which is the state machine of the block. It has three states: `PAT_FIVE`, `PAT_SIX` and `PAT_SEVEN`. Its only transition is taken on reset, into the state that `sel` decodes to. Without reset it stays in its current state, so a change of `sel` waits for the next reset. When `en` is low, the chains hold their contents and the serial bit does not change.

The chain lengths are 3, 4 and 6 stages. Three is the smallest count able to number five states. Four and six stages are needed because fewer stages cannot keep every window of the 6-bit and 7-bit strings distinct.

Top module: `patgen_top`

## Requirements
- R1: When `rst` is high at a falling edge, the block loads the seed of the pattern selected by `sel`. Afterwards `bit_o` is 1, the first bit of every pattern. `state_o` reads `000110` for the 5-bit pattern, `001110` for the 6-bit pattern and `111011` for the 7-bit pattern.
- R2: With `sel`=0 at reset and `en` high, `bit_o` repeats `11001`, one bit per falling edge, starting from the leftmost bit.
- R3: With `sel`=1 at reset and `en` high, `bit_o` repeats `101011`.
- R4: With `sel`=2 at reset and `en` high, `bit_o` repeats `1011011`.
- R5: With `sel`=3 at reset, the block behaves exactly as with `sel`=0.
- R6: `state_o` bit i is stage Qi of the active chain, and bits above the chain length are 0. On each enabled edge the top stage Q(n-1) takes the new output bit and each lower stage Qi takes Q(i+1). As a result, after t enabled edges, Qi holds pattern bit (t-(n-1-i)) mod N.
- R7: While `en` is low at a falling edge, `state_o` and `bit_o` keep their values.
- R8: A change of `sel` while `rst` is low has no effect on `bit_o` or `state_o` until the next reset.
- R9: Within any N consecutive enabled edges of one pattern of length N, no value of `state_o` repeats, and the all-zero state never occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous reset; loads the seeds and captures `sel` |
| sel | input | 2 | Pattern choice: 0 = 11001, 1 = 101011, 2 = 1011011, 3 = as 0 |
| en | input | 1 | Advance enable; low holds the state |
| bit_o | output | 1 | Serial pattern bit (top stage of the active chain) |
| state_o | output | 6 | Active chain contents, stage Qi on bit i, zero-extended |

## Verification
Each of the three selections is run for at least three full periods from reset, and the serial bit and the full state window are compared with a behavioural model on every clock. This separates the three feedback functions and their seeds, and a wrong seed shows up as a rotated string. The spare select code 3 is run to show that it falls back to the 5-bit pattern. Enable is dropped in the middle of a period, which separates holding from advancing. `sel` is changed without reset, and a reset is applied mid-run, which separates the mode capture from a live decode of `sel`. A per-period record of seen states confirms that every window is distinct.

// File: rtl/patgen_pkg.sv
`timescale 1ns/1ps
package patgen_pkg;
    localparam int SEL_W     = 2;
    localparam int LEN_FIVE  = 3;
    localparam int LEN_SIX   = 4;
    localparam int LEN_SEVEN = 6;
    localparam int MAX_A     = (LEN_FIVE > LEN_SIX) ? LEN_FIVE : LEN_SIX;
    localparam int STATE_W   = (MAX_A > LEN_SEVEN) ? MAX_A : LEN_SEVEN;

    // Seeds: newest bit in the top stage, chosen so the first bit out starts the pattern
    localparam logic [LEN_FIVE-1:0]  SEED_FIVE  = 3'b110;
    localparam logic [LEN_SIX-1:0]   SEED_SIX   = 4'b1110;
    localparam logic [LEN_SEVEN-1:0] SEED_SEVEN = 6'b111011;

    // Feedback variant selectors for the chain module
    localparam int FB_FIVE  = 0;
    localparam int FB_SIX   = 1;
    localparam int FB_SEVEN = 2;

    typedef enum logic [SEL_W-1:0] {
        PAT_FIVE  = 2'd0,
        PAT_SIX   = 2'd1,
        PAT_SEVEN = 2'd2
    } pat_e;
endpackage

// File: rtl/patgen_chain.sv
`timescale 1ns/1ps
module patgen_chain #(
    parameter int                STAGES = 3,
    parameter int                KIND   = 0,
    parameter logic [STAGES-1:0] SEED   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [STAGES-1:0] q
);
    logic fb;
    logic armed;

    generate
        if (KIND == 0) begin : g_fb_five
            assign fb = ~q[0] | ~q[1];
        end else if (KIND == 1) begin : g_fb_six
            assign fb = ~q[3] | ~q[1] | (~q[2] & ~q[0]);
        end else begin : g_fb_seven
            assign fb = ~q[STAGES-1] | ~q[STAGES-2] | ~q[0];
        end
    endgenerate

    always_ff @(negedge clk) begin
        if (rst) begin
            q <= SEED;
        end else if (en) begin
            q <= {fb, q[STAGES-1:1]};
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    // R6: lower stages follow the stage above on an enabled edge
    assert_shift_R6: assert property (@(negedge clk) disable iff (rst)
        (armed && en) |=> (q[STAGES-2:0] == $past(q[STAGES-1:1])));

    // R7: a disabled edge leaves the chain untouched
    assert_hold_R7: assert property (@(negedge clk) disable iff (rst)
        (armed && !en) |=> $stable(q));

    // R9: the chain never drops out of its cycle into the all-zero state
    assert_nonzero_R9: assert property (@(negedge clk) disable iff (rst)
        armed |-> (q != '0));
endmodule

// File: rtl/patgen_top.sv
`timescale 1ns/1ps
module patgen_top
    import patgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic               bit_o,
    output logic [STATE_W-1:0] state_o
);
    pat_e                 mode_q;
    pat_e                 mode_d;
    logic                 armed;
    logic [LEN_FIVE-1:0]  q_five;
    logic [LEN_SIX-1:0]   q_six;
    logic [LEN_SEVEN-1:0] q_seven;

    function automatic pat_e decode_sel(input logic [SEL_W-1:0] s);
        pat_e m;
        unique case (s)
            2'd1:    m = PAT_SIX;
            2'd2:    m = PAT_SEVEN;
            default: m = PAT_FIVE;
        endcase
        return m;
    endfunction

    // Mode transition: only taken under reset
    always_comb begin
        mode_d = rst ? decode_sel(sel) : mode_q;
    end

    always_ff @(negedge clk) begin
        mode_q <= mode_d;
        if (rst) begin
            armed <= 1'b1;
        end
    end

    patgen_chain #(.STAGES(LEN_FIVE), .KIND(FB_FIVE), .SEED(SEED_FIVE)) u_chain_five (
        .clk(clk), .rst(rst), .en(en), .q(q_five)
    );

    patgen_chain #(.STAGES(LEN_SIX), .KIND(FB_SIX), .SEED(SEED_SIX)) u_chain_six (
        .clk(clk), .rst(rst), .en(en), .q(q_six)
    );

    patgen_chain #(.STAGES(LEN_SEVEN), .KIND(FB_SEVEN), .SEED(SEED_SEVEN)) u_chain_seven (
        .clk(clk), .rst(rst), .en(en), .q(q_seven)
    );

    // Output process: route the active chain
    always_comb begin
        bit_o   = q_five[LEN_FIVE-1];
        state_o = STATE_W'(q_five);
        unique case (mode_q)
            PAT_SIX: begin
                bit_o   = q_six[LEN_SIX-1];
                state_o = STATE_W'(q_six);
            end
            PAT_SEVEN: begin
                bit_o   = q_seven[LEN_SEVEN-1];
                state_o = STATE_W'(q_seven);
            end
            default: begin
                bit_o   = q_five[LEN_FIVE-1];
                state_o = STATE_W'(q_five);
            end
        endcase
    end

    // R1: every pattern starts with a 1 right after reset
    assert_first_one_R1: assert property (@(negedge clk)
        rst |=> bit_o);

    // R8: the mode only moves under reset
    assert_mode_locked_R8: assert property (@(negedge clk) disable iff (rst)
        armed |=> $stable(mode_q));
endmodule

// File: tb/patgen_top_bench.sv
`timescale 1ns/1ps
module patgen_top_bench;
    import patgen_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [SEL_W-1:0]   sel = '0;
    logic               bit_o;
    logic [STATE_W-1:0] state_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int t     = 0;
    int cur   = 0;
    bit seen [int];

    patgen_top u_patgen_top (
        .clk(clk), .rst(rst), .sel(sel), .en(en), .bit_o(bit_o), .state_o(state_o)
    );

    always #2.5 clk = ~clk;

    function automatic string pat_of(int m);
        case (m)
            0:       return "11001";
            1:       return "101011";
            default: return "1011011";
        endcase
    endfunction

    function automatic int stages_of(int m);
        case (m)
            0:       return 3;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic pbit(int m, int idx);
        string p = pat_of(m);
        int n = p.len();
        int k = ((idx % n) + n) % n;
        return (p[k] == "1");
    endfunction

    function automatic logic [STATE_W-1:0] exp_state(int m, int tt);
        logic [STATE_W-1:0] s = '0;
        int n = stages_of(m);
        for (int i = 0; i < n; i++) begin
            s[i] = pbit(m, tt - (n - 1 - i));
        end
        return s;
    endfunction

    task automatic check(string req, logic [STATE_W-1:0] act, logic [STATE_W-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, expv);
        end
    endtask

    task automatic check_now(string req, bit uniq);
        int n = pat_of(cur).len();
        check(req, STATE_W'(bit_o), STATE_W'(pbit(cur, t)));
        check({"R6 ", req}, state_o, exp_state(cur, t));
        if (uniq) begin
            if (t % n == 0) seen.delete();
            total++;
            if (seen.exists(int'(state_o))) begin
                bad++;
                $display("FAIL R9 t=%0d actual=%b expected=a state not seen this period", t, state_o);
            end
            seen[int'(state_o)] = 1'b1;
        end
    endtask

    task automatic apply_reset(logic [SEL_W-1:0] s);
        sel = s;
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        cur = (s == 2'd3) ? 0 : int'(s);
        t   = 0;
        seen.delete();
        check_now("R1", 1'b1);
    endtask

    task automatic advance(int cycles, logic en_val, string req);
        for (int c = 0; c < cycles; c++) begin
            en = en_val;
            @(posedge clk); #1;
            if (en_val) t++;
            check_now(req, en_val);
        end
    endtask

    initial begin
        @(posedge clk); #1;
        apply_reset(2'd0);
        advance(15, 1'b1, "R2");
        sel = 2'd2;                    // no reset: must be ignored
        advance(10, 1'b1, "R8");
        apply_reset(2'd1);
        advance(18, 1'b1, "R3");
        advance(3, 1'b0, "R7");
        advance(6, 1'b1, "R3");
        apply_reset(2'd2);
        advance(21, 1'b1, "R4");
        advance(2, 1'b0, "R7");
        advance(7, 1'b1, "R4");
        apply_reset(2'd3);
        advance(15, 1'b1, "R5");
        apply_reset(2'd2);
        advance(4, 1'b1, "R4");
        apply_reset(2'd0);             // reset in mid-period restarts the string
        advance(5, 1'b1, "R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule